// File: doc/BRIEF.md
# Interrupt Level Gate and Status Register

This block keeps a 32-bit core status word. The word holds three hardware-loop enable flags and a 3-bit interrupt mask. A single pending request comes in with a 3-bit priority level or a non-maskable marker. The block decides in the same cycle whether the request may interrupt the core.

When a request is admitted, the block raises a one-cycle accept strobe. In that same cycle it presents the unmodified status word on a save output, so that an external stack unit can push it. On the next clock edge it rewrites the status word for the service-routine context: the loop flags are cleared and the mask takes on the level being serviced.

Software changes the word through a plain write port. A return from interrupt is just a write of a previously saved word through that same port.

Top module: `irq_level_gate`

## Requirements
- R1: After reset the status word reads 0x00E00000. The mask field (bits 23:21) is 7 and the loop flags (bits 29:27) are 0.
- R2: A maskable request (req_nmi = 0) is accepted only when its level is strictly greater than the current mask. A level-0 request is never accepted, whatever the mask holds.
- R3: A valid non-maskable request (req_nmi = 1) is always accepted, including when the mask is 7.
- R4: In an accept cycle, save_word_o equals the status word as it stood before the update. When accept_o is low, save_word_o is 0.
- R5: The clock edge that ends an accept cycle clears bits 29:27 and loads bits 23:21 with the accepted level. All other bits keep their values.
- R6: A non-maskable acceptance loads the mask field with 7.
- R7: When wr_en is high and no request is accepted, the next edge loads wr_data into the status word, with reserved bits 26:24 forced to 0.
- R8: When a write and an acceptance happen in the same cycle, the acceptance update wins and the write data is discarded.
- R9: Reserved bits 26:24 of status_o always read 0.
- R10: accept_o is low whenever req_valid is low.
- R11: mask_o mirrors bits 23:21. loop_en_o bit i mirrors status bit 27+i, so hardware loop i+1 is enabled when that bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | A request is pending |
| req_level | input | 3 | Priority level of the pending request |
| req_nmi | input | 1 | Pending request is non-maskable |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 32 | Software write value |
| accept_o | output | 1 | Request accepted this cycle (one-cycle strobe) |
| save_word_o | output | 32 | Pre-update status word in an accept cycle, else 0 |
| status_o | output | 32 | Current status word |
| mask_o | output | 3 | Current interrupt mask field |
| loop_en_o | output | 3 | Hardware-loop enable flags (bit 0 = loop 1) |

## Verification
The hardest situation to reach from the ports is a software write that lands in the same cycle as an acceptance while the loop flags are set. That is the only case in which the update-priority rule is visible. The bench first writes a word with all flags set and a known mask. It then drives a new write and an admitted request together, and checks that the flags clear, the mask takes the request level, and no bit of the write data survives. The main sweep steps through every mask value crossed with every level and both request kinds. Each case starts with a fresh written word, so every accept and reject boundary, including the strict-greater edge and the level-0 floor, is covered.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;

  localparam int unsigned IRQ_LVL_W = 3;

  typedef logic [IRQ_LVL_W-1:0] irq_lvl_t;

  // Admission rule: non-maskable always passes; otherwise strictly above mask,
  // and level zero never passes.
  function automatic logic lvl_admits(input irq_lvl_t lvl, input logic nmi,
                                      input irq_lvl_t mask);
    logic above;
    above = (lvl != '0) && (lvl > mask);
    return nmi | above;
  endfunction

  // Mask value loaded when entering the service context.
  function automatic irq_lvl_t entry_mask(input irq_lvl_t lvl, input logic nmi);
    return nmi ? {IRQ_LVL_W{1'b1}} : lvl;
  endfunction

endpackage

// File: rtl/irq_accept_unit.sv
module irq_accept_unit
  import irq_gate_pkg::*;
(
  input  logic     req_valid,
  input  irq_lvl_t req_level,
  input  logic     req_nmi,
  input  irq_lvl_t cur_mask,
  output logic     grant,
  output irq_lvl_t svc_mask
);

  always_comb begin
    grant    = req_valid & lvl_admits(req_level, req_nmi, cur_mask);
    svc_mask = entry_mask(req_level, req_nmi);
  end

endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
  parameter int unsigned WORD_W   = 32,
  parameter int unsigned LVL_W    = 3,
  parameter int unsigned MASK_LSB = 21,
  parameter int unsigned LOOP_LSB = 27,
  parameter int unsigned LOOP_N   = 3,
  parameter int unsigned RSV_LSB  = 24,
  parameter int unsigned RSV_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              grant,
  input  logic [LVL_W-1:0]  svc_mask,
  output logic [WORD_W-1:0] status_q,
  output logic [WORD_W-1:0] status_nxt
);

  localparam logic [WORD_W-1:0] RSV_BITS =
    {{(WORD_W-RSV_W){1'b0}}, {RSV_W{1'b1}}} << RSV_LSB;
  localparam logic [WORD_W-1:0] RST_WORD =
    {{(WORD_W-LVL_W){1'b0}}, {LVL_W{1'b1}}} << MASK_LSB;

  // Next-state selection: the service-entry update has priority over writes.
  always_comb begin
    status_nxt = status_q;
    if (grant) begin
      status_nxt[LOOP_LSB +: LOOP_N] = '0;
      status_nxt[MASK_LSB +: LVL_W]  = svc_mask;
    end else if (wr_en) begin
      status_nxt = wr_data;
    end
    status_nxt = status_nxt & ~RSV_BITS;
  end

  // Per-bit storage; reserved positions hold no flop.
  for (genvar b = 0; b < WORD_W; b++) begin : g_bit
    if (RSV_BITS[b]) begin : g_rsv
      assign status_q[b] = 1'b0;
    end else begin : g_flop
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status_q[b] <= RST_WORD[b];
        else        status_q[b] <= status_nxt[b];
      end
    end
  end

endmodule

// File: rtl/irq_level_gate.sv
module irq_level_gate
  import irq_gate_pkg::*;
#(
  parameter int unsigned WORD_W   = 32,
  parameter int unsigned MASK_LSB = 21,
  parameter int unsigned LOOP_LSB = 27,
  parameter int unsigned LOOP_N   = 3,
  parameter int unsigned RSV_LSB  = 24,
  parameter int unsigned RSV_W    = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [IRQ_LVL_W-1:0] req_level,
  input  logic                 req_nmi,
  input  logic                 wr_en,
  input  logic [WORD_W-1:0]    wr_data,
  output logic                 accept_o,
  output logic [WORD_W-1:0]    save_word_o,
  output logic [WORD_W-1:0]    status_o,
  output logic [IRQ_LVL_W-1:0] mask_o,
  output logic [LOOP_N-1:0]    loop_en_o
);

  // Named internal events, visible to the bound checker.
  logic              grant;
  irq_lvl_t          svc_mask;
  irq_lvl_t          cur_mask;
  logic [WORD_W-1:0] status_q;
  logic [WORD_W-1:0] status_nxt;

  assign cur_mask = status_q[MASK_LSB +: IRQ_LVL_W];

  irq_accept_unit u_accept (
    .req_valid (req_valid),
    .req_level (req_level),
    .req_nmi   (req_nmi),
    .cur_mask  (cur_mask),
    .grant     (grant),
    .svc_mask  (svc_mask)
  );

  irq_status_reg #(
    .WORD_W   (WORD_W),
    .LVL_W    (IRQ_LVL_W),
    .MASK_LSB (MASK_LSB),
    .LOOP_LSB (LOOP_LSB),
    .LOOP_N   (LOOP_N),
    .RSV_LSB  (RSV_LSB),
    .RSV_W    (RSV_W)
  ) u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .grant      (grant),
    .svc_mask   (svc_mask),
    .status_q   (status_q),
    .status_nxt (status_nxt)
  );

  assign accept_o    = grant;
  assign save_word_o = grant ? status_q : '0;
  assign status_o    = status_q;
  assign mask_o      = cur_mask;
  assign loop_en_o   = status_q[LOOP_LSB +: LOOP_N];

endmodule

// File: rtl/irq_level_gate_chk.sv
module irq_level_gate_chk #(
  parameter int unsigned WORD_W   = 32,
  parameter int unsigned MASK_LSB = 21,
  parameter int unsigned LOOP_LSB = 27,
  parameter int unsigned LOOP_N   = 3,
  parameter int unsigned RSV_LSB  = 24,
  parameter int unsigned RSV_W    = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [2:0]        req_level,
  input logic              req_nmi,
  input logic              wr_en,
  input logic [WORD_W-1:0] wr_data,
  input logic              accept_o,
  input logic [WORD_W-1:0] save_word_o,
  input logic [WORD_W-1:0] status_o
);

  localparam logic [WORD_W-1:0] RSV_BITS =
    {{(WORD_W-RSV_W){1'b0}}, {RSV_W{1'b1}}} << RSV_LSB;

  AST_LEVEL0_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_nmi && req_level == 3'd0) |-> !accept_o); // R2

  AST_NMI_ADMITTED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_nmi) |-> accept_o); // R3

  AST_SAVE_PREVIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o |=> (status_o[MASK_LSB +: 3] != $past(status_o[MASK_LSB +: 3]) ||
                  $past(save_word_o) == $past(status_o))); // R4

  AST_LOOPS_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o |=> status_o[LOOP_LSB +: LOOP_N] == '0); // R5

  AST_MASK_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_o && !req_nmi) |=> status_o[MASK_LSB +: 3] == $past(req_level)); // R5

  AST_NMI_MASK_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_o && req_nmi) |=> status_o[MASK_LSB +: 3] == 3'd7); // R6

  AST_WRITE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !accept_o) |=> status_o == ($past(wr_data) & ~RSV_BITS)); // R7

  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o & RSV_BITS) == '0); // R9

  AST_IDLE_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !accept_o); // R10

endmodule

bind irq_level_gate irq_level_gate_chk #(
  .WORD_W   (WORD_W),
  .MASK_LSB (MASK_LSB),
  .LOOP_LSB (LOOP_LSB),
  .LOOP_N   (LOOP_N),
  .RSV_LSB  (RSV_LSB),
  .RSV_W    (RSV_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_level   (req_level),
  .req_nmi     (req_nmi),
  .wr_en       (wr_en),
  .wr_data     (wr_data),
  .accept_o    (accept_o),
  .save_word_o (save_word_o),
  .status_o    (status_o)
);

// File: tb/irq_level_gate_tb.sv
module irq_level_gate_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_level = '0;
  logic        req_nmi = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        accept_o;
  logic [31:0] save_word_o;
  logic [31:0] status_o;
  logic [2:0]  mask_o;
  logic [2:0]  loop_en_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  irq_level_gate u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_level   (req_level),
    .req_nmi     (req_nmi),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .accept_o    (accept_o),
    .save_word_o (save_word_o),
    .status_o    (status_o),
    .mask_o      (mask_o),
    .loop_en_o   (loop_en_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Fields: loops 29:27, reserved 26:24, mask 23:21.
  function automatic logic [31:0] compose(input logic [2:0] loops, input logic [2:0] m,
                                          input logic [31:0] other);
    return (other & 32'hC01F_FFFF) | ({29'd0, loops} << 27) | ({29'd0, m} << 21);
  endfunction

  task automatic do_write(input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d; req_valid = 1'b0;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset word", status_o, 32'h00E0_0000);
    chk("R11 reset mask", {29'd0, mask_o}, 32'd7);
    chk("R11 reset loops", {29'd0, loop_en_o}, 32'd0);
    chk("R10 idle accept", {31'd0, accept_o}, 32'd0);
    chk("R4 idle save", save_word_o, 32'd0);
    req_valid = 1'b1; req_level = 3'd7; req_nmi = 1'b0; #1;
    chk("R2 level7 vs mask7", {31'd0, accept_o}, 32'd0);
    req_nmi = 1'b1; #1;
    chk("R3 nmi vs mask7", {31'd0, accept_o}, 32'd1);
    req_valid = 1'b0; req_nmi = 1'b0; #1;
    chk("R10 valid low", {31'd0, accept_o}, 32'd0);

    // Full sweep: every mask x every level x both request kinds.
    for (int m = 0; m < 8; m++) begin
      for (int l = 0; l < 8; l++) begin
        for (int n = 0; n < 2; n++) begin
          logic [31:0] base, exp_after;
          logic        exp_acc;
          logic [2:0]  loops, nm;
          loops = 3'(m + l + n + 1);
          base  = compose(loops, 3'(m), 32'h9A5C_3E17 ^ (32'(m * 131 + l * 17 + n)));
          do_write(base);
          chk("R7 write load", status_o, base);
          chk("R11 mask field", {29'd0, mask_o}, {29'd0, 3'(m)});
          chk("R11 loop field", {29'd0, loop_en_o}, {29'd0, loops});
          req_valid = 1'b1; req_level = 3'(l); req_nmi = n[0]; #1;
          exp_acc = (n == 1) || (l != 0 && l > m);
          chk(n == 1 ? "R3 nmi decision" : "R2 level decision",
              {31'd0, accept_o}, {31'd0, exp_acc});
          chk("R4 saved word", save_word_o, exp_acc ? base : 32'd0);
          nm = (n == 1) ? 3'd7 : 3'(l);
          exp_after = exp_acc ? compose(3'd0, nm, base) : base;
          @(negedge clk);
          req_valid = 1'b0; req_nmi = 1'b0;
          chk(n == 1 ? "R6 nmi entry" : "R5 entry update", status_o, exp_after);
        end
      end
    end

    // R8: write collides with an accepted request.
    do_write(compose(3'b111, 3'd2, 32'h1234_5678));
    @(negedge clk);
    wr_en = 1'b1; wr_data = 32'hFFFF_FFFF;
    req_valid = 1'b1; req_level = 3'd5; req_nmi = 1'b0; #1;
    chk("R8 accept during write", {31'd0, accept_o}, 32'd1);
    @(negedge clk);
    wr_en = 1'b0; req_valid = 1'b0;
    chk("R8 accept wins", status_o, compose(3'd0, 3'd5, 32'h1234_5678));

    // R8 with a rejected request: the write goes through.
    @(negedge clk);
    wr_en = 1'b1; wr_data = 32'h0000_00AA;
    req_valid = 1'b1; req_level = 3'd3; #1;
    chk("R8 rejected during write", {31'd0, accept_o}, 32'd0);
    @(negedge clk);
    wr_en = 1'b0; req_valid = 1'b0;
    chk("R7 write when rejected", status_o, 32'h0000_00AA);

    // R9: reserved bits ignore writes.
    do_write(32'hFFFF_FFFF);
    chk("R9 reserved zero", status_o, 32'hF8FF_FFFF);
    do_write(32'h0700_0000);
    chk("R9 reserved only", status_o, 32'h0000_0000);

    // R1: reset returns to the default word.
    do_write(32'h3800_0000);
    rst_n = 1'b0; #1;
    chk("R1 async reset", status_o, 32'h00E0_0000);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", status_o, 32'h00E0_0000);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule